// File: doc/BRIEF.md
# Thermal Threshold Monitor

This block watches a digital die-temperature code and raises a level interrupt request when the temperature moves past one of two programmable limits. A fixed offset comes in from fuses on a separate input. The block adds this signed offset to each raw reading, clamps the sum to the 7-bit code range, and uses the clamped result in every comparison. Comparisons happen only when a programmable down-counter expires. The counter stays stopped while the unit-enable bit is clear, so a freshly reset block does no work.

Each limit register holds a threshold level and a direction bit that selects "above" or "below". It also has a compare-enable bit and an interrupt-enable bit, plus two sticky flags: valid and result. Enabling one limit gives single-threshold operation, and enabling both gives dual-threshold operation. Software reads and writes the registers through a single-cycle port with a 2-bit address. Software clears a flag by rewriting its limit register, or clears all result flags through the acknowledge input. The interrupt vector offset 0x1700 is driven as a constant beside the request.

Top module: `thermal_watch`

## Requirements
- R1: While the unit is enabled with interval value N in the control register, a comparison is taken every N+1 clock edges. The first comparison falls on the (N+1)th edge after the edge that wrote the enable bit, provided N was written earlier. N = 0 compares on every edge.
- R2: While the unit-enable bit (control bit 0) is clear, no comparison is taken, no result or valid flag is set, and the timer holds the interval value.
- R3: A limit with direction bit 8 set is crossed when the corrected temperature is strictly greater than its level (bits 6:0). With direction bit 8 clear, it is crossed when the corrected temperature is strictly smaller. Equality never counts as a crossing.
- R4: Only a limit whose compare-enable bit 9 is set takes part in a comparison. Limit 0 (address 0) and limit 1 (address 1) work independently, so enabling both gives dual-threshold operation.
- R5: When a comparison finds an enabled limit crossed, that limit's valid flag (bit 30) and result flag (bit 31) are set and stay set until they are cleared.
- R6: The corrected temperature is the raw 7-bit code plus the 8-bit two's-complement fuse offset, clamped to the range 0 to 127.
- R7: A write to a limit register replaces its level, direction, compare-enable and interrupt-enable bits and clears its valid and result flags. The write wins over a comparison on the same edge.
- R8: The interrupt request is high exactly while some limit has both its result flag and its interrupt-enable bit 10 set. It is visible in the cycle after the edge that set the flag.
- R9: A high on the acknowledge input at an edge clears the result flags of both limits and leaves the valid flags unchanged. A comparison that sets a result flag on the same edge takes precedence.
- R10: Reset clears every bit of addresses 0 to 2. Address 3 always reads the fuse input in bits 7:0 with zeros above, and writes to address 3 have no effect.
- R11: The vector output is constantly 0x1700.
- R12: Read data is combinational from the address. The control register reads the enable bit in bit 0 and the 13-bit interval in bits 13:1. Unlisted bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address (0,1 limits, 2 control, 3 fuse offset) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| temp_raw | input | 7 | Raw temperature code from the sensor path |
| fuse_ofs | input | 8 | Signed factory offset |
| irq_ack | input | 1 | Interrupt acknowledge, clears result flags |
| irq_req | output | 1 | Thermal interrupt request, level |
| irq_vector | output | 16 | Constant vector offset 0x1700 |

## Verification
Read data follows the address inside the same cycle. A register write shows up in read data in the cycle after its edge. A comparison's flags and the request it causes appear in the cycle after the edge on which the timer reached zero, which is edge N+1 after the enabling write. The bench keeps a behavioural model that it advances on each rising edge with the inputs the design saw there. On every falling edge, before it drives new inputs, it compares the request, the vector and the read data at the current address against that model. Any change in that timing shows up as a mismatch in a known cycle.

// File: rtl/thw_pkg.sv
package thw_pkg;
   parameter int unsigned THW_TEMP_W = 7;

   typedef enum logic [1:0] {
      ADR_LIM0 = 2'd0,
      ADR_LIM1 = 2'd1,
      ADR_CTRL = 2'd2,
      ADR_FUSE = 2'd3
   } thw_addr_e;

   localparam int unsigned POS_DIR = 8;
   localparam int unsigned POS_CMP = 9;
   localparam int unsigned POS_IEN = 10;
   localparam int unsigned POS_VLD = 30;
   localparam int unsigned POS_RES = 31;
   localparam int unsigned POS_EN  = 0;
   localparam int unsigned POS_IVL = 1;

   typedef struct packed {
      logic                  irq_en;
      logic                  cmp_en;
      logic                  above;
      logic [THW_TEMP_W-1:0] level;
   } thw_lim_t;
endpackage

// File: rtl/thw_offset.sv
module thw_offset #(
   parameter int unsigned TEMP_W   = 7,
   parameter int unsigned OFS_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic [TEMP_W-1:0] raw_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [TEMP_W-1:0] corr_o
);
   localparam int unsigned SUM_W = ((TEMP_W > OFS_W) ? TEMP_W : OFS_W) + 2;
   localparam logic signed [SUM_W-1:0] TOP_V = SUM_W'((1 << TEMP_W) - 1);

   logic signed [SUM_W-1:0] raw_s;
   logic signed [SUM_W-1:0] ofs_s;
   logic signed [SUM_W-1:0] sum_s;

   assign raw_s = $signed({{(SUM_W-TEMP_W){1'b0}}, raw_i});
   assign ofs_s = $signed({{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
   assign sum_s = raw_s + ofs_s;

   generate
      if (SATURATE) begin : g_clamp
         always_comb begin
            if (sum_s < 0)           corr_o = '0;
            else if (sum_s > TOP_V)  corr_o = '1;
            else                     corr_o = sum_s[TEMP_W-1:0];
         end
      end else begin : g_wrap
         assign corr_o = sum_s[TEMP_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/thw_interval.sv
module thw_interval #(
   parameter int unsigned IVL_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [IVL_W-1:0] ivl_i,
   output logic             tick_o
);
   logic [IVL_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!en_i)          cnt_q <= ivl_i;
      else if (cnt_q == '0)    cnt_q <= ivl_i;
      else                     cnt_q <= cnt_q - 1'b1;
   end

   assign tick_o = en_i && (cnt_q == '0);

   // R1: a non-zero interval never gives two samples on adjacent edges
   a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && ivl_i != '0) |=> !tick_o);
endmodule

// File: rtl/thw_limit.sv
module thw_limit
   import thw_pkg::*;
#(
   parameter int unsigned TEMP_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  thw_lim_t          cfg_i,
   input  logic              tick_i,
   input  logic              ack_i,
   input  logic [TEMP_W-1:0] corr_i,
   output thw_lim_t          cfg_o,
   output logic              vld_o,
   output logic              res_o,
   output logic              irq_o
);
   thw_lim_t cfg_q;
   logic     vld_q, res_q;
   logic     crossed, hit;

   assign crossed = cfg_q.above ? (corr_i > cfg_q.level) : (corr_i < cfg_q.level);
   assign hit     = tick_i && cfg_q.cmp_en && crossed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         vld_q <= 1'b0;
         res_q <= 1'b0;
      end else if (wr_i) begin
         cfg_q <= cfg_i;
         vld_q <= 1'b0;
         res_q <= 1'b0;
      end else if (hit) begin
         vld_q <= 1'b1;
         res_q <= 1'b1;
      end else if (ack_i) begin
         res_q <= 1'b0;
      end
   end

   assign cfg_o = cfg_q;
   assign vld_o = vld_q;
   assign res_o = res_q;
   assign irq_o = res_q && cfg_q.irq_en;

   // R5: a result flag only appears after a sample strobe
   a_r5_set_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_q) |-> $past(tick_i));
   // R7: a register write leaves both sticky flags clear
   a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (!res_q && !vld_q));
endmodule

// File: rtl/thermal_watch.sv
module thermal_watch
   import thw_pkg::*;
#(
   parameter int unsigned TEMP_W   = 7,
   parameter int unsigned OFS_W    = 8,
   parameter int unsigned IVL_W    = 13,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned VEC_W    = 16,
   parameter logic [15:0] VEC_OFS  = 16'h1700,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [TEMP_W-1:0] temp_raw,
   input  logic [OFS_W-1:0]  fuse_ofs,
   input  logic              irq_ack,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vector
);
   localparam int unsigned NUM_LIM = 2;
   localparam int unsigned IVL_HI  = POS_IVL + IVL_W - 1;

   initial begin
      if (TEMP_W != THW_TEMP_W) $fatal(1, "TEMP_W must match package width");
      if (DATA_W < POS_RES + 1) $fatal(1, "DATA_W too narrow for register map");
      if (IVL_HI >= POS_VLD)    $fatal(1, "interval field overlaps flags");
      if (OFS_W > DATA_W)       $fatal(1, "offset wider than data");
   end

   logic              en_q;
   logic [IVL_W-1:0]  ivl_q;
   logic              tick;
   logic [TEMP_W-1:0] corr;
   thw_lim_t          wr_cfg;
   thw_lim_t          lim_cfg [NUM_LIM];
   logic [NUM_LIM-1:0] lim_vld, lim_res, lim_irq;
   logic              unused_wbits;

   assign unused_wbits = ^{reg_wdata[DATA_W-1:IVL_HI+1], reg_wdata[TEMP_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ivl_q <= '0;
      end else if (reg_wr && reg_addr == ADR_CTRL) begin
         en_q  <= reg_wdata[POS_EN];
         ivl_q <= reg_wdata[IVL_HI:POS_IVL];
      end
   end

   thw_interval #(.IVL_W(IVL_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .en_i(en_q), .ivl_i(ivl_q), .tick_o(tick)
   );

   thw_offset #(.TEMP_W(TEMP_W), .OFS_W(OFS_W), .SATURATE(SATURATE)) u_ofs (
      .raw_i(temp_raw), .ofs_i(fuse_ofs), .corr_o(corr)
   );

   assign wr_cfg.level  = reg_wdata[TEMP_W-1:0];
   assign wr_cfg.above  = reg_wdata[POS_DIR];
   assign wr_cfg.cmp_en = reg_wdata[POS_CMP];
   assign wr_cfg.irq_en = reg_wdata[POS_IEN];

   generate
      for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
         thw_limit #(.TEMP_W(TEMP_W)) u_lim (
            .clk(clk), .rst_n(rst_n),
            .wr_i(reg_wr && reg_addr == 2'(i)),
            .cfg_i(wr_cfg), .tick_i(tick), .ack_i(irq_ack), .corr_i(corr),
            .cfg_o(lim_cfg[i]), .vld_o(lim_vld[i]), .res_o(lim_res[i]),
            .irq_o(lim_irq[i])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADR_LIM0, ADR_LIM1: begin
            reg_rdata[TEMP_W-1:0] = lim_cfg[reg_addr[0]].level;
            reg_rdata[POS_DIR]    = lim_cfg[reg_addr[0]].above;
            reg_rdata[POS_CMP]    = lim_cfg[reg_addr[0]].cmp_en;
            reg_rdata[POS_IEN]    = lim_cfg[reg_addr[0]].irq_en;
            reg_rdata[POS_VLD]    = lim_vld[reg_addr[0]];
            reg_rdata[POS_RES]    = lim_res[reg_addr[0]];
         end
         ADR_CTRL: begin
            reg_rdata[POS_EN]         = en_q;
            reg_rdata[IVL_HI:POS_IVL] = ivl_q;
         end
         default: reg_rdata[OFS_W-1:0] = fuse_ofs;
      endcase
   end

   assign irq_req    = |lim_irq;
   assign irq_vector = VEC_W'(VEC_OFS);

   // R2: no flag may rise out of a cycle where the unit was disabled
   a_r2_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> ((lim_res & ~$past(lim_res)) == '0));
   // R8: a request always has a result flag behind it
   a_r8_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (lim_res != '0));
endmodule

// File: tb/thermal_watch_bench.sv
`timescale 1ns/1ps
module thermal_watch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [6:0]  temp_raw = '0;
   logic [7:0]  fuse_ofs = '0;
   logic        irq_ack = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vector;

   always #2 clk = ~clk;

   thermal_watch u_thermal_watch (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .temp_raw(temp_raw),
      .fuse_ofs(fuse_ofs), .irq_ack(irq_ack), .irq_req(irq_req),
      .irq_vector(irq_vector)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string phase = "R10 reset";
   bit    done = 1'b0;

   // behavioural reference state
   bit m_en = 0;
   int m_ivl = 0;
   int m_cnt = 0;
   int m_thr [2] = '{0, 0};
   bit m_dir [2] = '{0, 0};
   bit m_ce  [2] = '{0, 0};
   bit m_ie  [2] = '{0, 0};
   bit m_vld [2] = '{0, 0};
   bit m_res [2] = '{0, 0};
   int m_corr;
   bit m_tick;
   bit m_cross;

   function automatic int corrected(input logic [6:0] raw, input logic [7:0] ofs);
      int s;
      s = int'(raw) + int'($signed(ofs));
      if (s < 0) s = 0;
      if (s > 127) s = 127;
      return s;
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         m_corr = corrected(temp_raw, fuse_ofs);
         m_tick = m_en && (m_cnt == 0);
         for (int i = 0; i < 2; i++) begin
            m_cross = m_dir[i] ? (m_corr > m_thr[i]) : (m_corr < m_thr[i]);
            if (reg_wr && reg_addr == 2'(i)) begin
               m_thr[i] = int'(reg_wdata[6:0]);
               m_dir[i] = reg_wdata[8];
               m_ce[i]  = reg_wdata[9];
               m_ie[i]  = reg_wdata[10];
               m_vld[i] = 0;
               m_res[i] = 0;
            end else if (m_tick && m_ce[i] && m_cross) begin
               m_vld[i] = 1;
               m_res[i] = 1;
            end else if (irq_ack) begin
               m_res[i] = 0;
            end
         end
         if (!m_en || m_cnt == 0) m_cnt = m_ivl;
         else                     m_cnt = m_cnt - 1;
         if (reg_wr && reg_addr == 2'd2) begin
            m_en  = reg_wdata[0];
            m_ivl = int'(reg_wdata[13:1]);
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [1:0] a);
      logic [31:0] d;
      d = '0;
      if (a < 2) begin
         d[6:0] = 7'(m_thr[a]);
         d[8]   = m_dir[a];
         d[9]   = m_ce[a];
         d[10]  = m_ie[a];
         d[30]  = m_vld[a];
         d[31]  = m_res[a];
      end else if (a == 2) begin
         d[0]    = m_en;
         d[13:1] = 13'(m_ivl);
      end else begin
         d[7:0] = fuse_ofs;
      end
      return d;
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", phase, what, act, exp, $time);
      end
   endtask

   int rot = 0;

   task automatic step(input bit w, input logic [1:0] a, input logic [31:0] d, input bit k);
      @(negedge clk);
      chk("R8 irq_req", {31'd0, irq_req}, {31'd0, (m_res[0] & m_ie[0]) | (m_res[1] & m_ie[1])});
      chk("R11 vector", {16'd0, irq_vector}, 32'h1700);
      chk("R12 rd_data", reg_rdata, exp_rd(reg_addr));
      reg_wr = w; reg_addr = a; reg_wdata = d; irq_ack = k;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         step(1'b0, 2'(rot), 32'h0, 1'b0);
         rot++;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0);
   endtask

   function automatic logic [31:0] lim(input int thr, input bit dir, input bit ce, input bit ie);
      logic [31:0] d;
      d = '0;
      d[6:0] = 7'(thr); d[8] = dir; d[9] = ce; d[10] = ie;
      return d;
   endfunction

   function automatic logic [31:0] ctl(input bit en, input int ivl);
      logic [31:0] d;
      d = '0;
      d[0] = en; d[13:1] = 13'(ivl);
      return d;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(8);                                   // R10 reset values

      phase = "R10 fuse write ignored";
      fuse_ofs = 8'd5;
      wr(2'd3, 32'hFFFF_FFFF);
      idle(4);

      phase = "R1 interval and R3 above";
      wr(2'd2, ctl(0, 3));
      wr(2'd0, lim(60, 1, 1, 1));
      temp_raw = 7'd55;                          // corrected 60: equal, not crossed
      wr(2'd2, ctl(1, 3));
      idle(12);
      phase = "R5 sticky set";
      temp_raw = 7'd56;                          // corrected 61 > 60
      idle(10);
      temp_raw = 7'd40;
      idle(6);

      phase = "R9 acknowledge";
      step(1'b0, 2'd0, 32'h0, 1'b1);
      idle(6);

      phase = "R7 write clears";
      temp_raw = 7'd70;
      idle(5);
      wr(2'd0, lim(60, 1, 1, 1));
      idle(3);
      step(1'b0, 2'd0, 32'h0, 1'b0);
      idle(5);

      phase = "R4 dual threshold";
      wr(2'd0, lim(60, 1, 1, 1));
      wr(2'd1, lim(30, 0, 0, 1));                // compare disabled
      temp_raw = 7'd20;                          // corrected 25 < 30
      idle(10);
      wr(2'd1, lim(30, 0, 1, 1));
      idle(10);
      step(1'b0, 2'd1, 32'h0, 1'b1);
      temp_raw = 7'd100;
      idle(10);

      phase = "R6 saturation low";
      fuse_ofs = 8'hEC;                          // -20
      temp_raw = 7'd10;                          // corrected 0
      wr(2'd0, lim(0, 0, 1, 1));                 // 0 < 0 false
      wr(2'd1, lim(1, 0, 1, 0));                 // 0 < 1 true, irq disabled (R8)
      idle(10);

      phase = "R6 saturation high";
      fuse_ofs = 8'd100;
      temp_raw = 7'd100;                         // corrected 127
      wr(2'd1, lim(127, 1, 1, 1));               // equal, not crossed
      wr(2'd0, lim(126, 1, 1, 1));
      idle(10);

      phase = "R2 disabled";
      wr(2'd2, ctl(0, 2));
      wr(2'd0, lim(10, 1, 1, 1));
      wr(2'd1, lim(120, 0, 1, 1));
      temp_raw = 7'd50;
      fuse_ofs = 8'd0;
      idle(12);
      wr(2'd2, ctl(1, 2));
      idle(8);

      phase = "R1 interval zero";
      step(1'b0, 2'd0, 32'h0, 1'b1);
      wr(2'd2, ctl(0, 0));
      wr(2'd0, lim(60, 1, 1, 1));
      wr(2'd2, ctl(1, 0));
      temp_raw = 7'd61;
      idle(2);
      temp_raw = 7'd10;
      step(1'b0, 2'd0, 32'h0, 1'b1);
      idle(2);
      temp_raw = 7'd61;
      idle(4);

      phase = "R12 final read";
      idle(8);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog %s act=running exp=done", phase);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule